// File: doc/BRIEF.md
# Memory-Mapped GCD Register Peripheral

This block computes the greatest common divisor of two unsigned words and sits as an APB slave, so a processor can run it through a small register bank. Software writes two operands, writes a start command, polls a completion flag, and then reads the result. Reading the result consumes it: the captured value and the completion flag both return to zero. An interrupt line can stand in for polling when software enables it.

Inside, a sequencer and a datapath work by repeated subtraction. The sequencer latches both operands when it starts. It then compares them and subtracts the smaller from the larger until they are equal. The equal value is the result. A one-cycle completion pulse from the sequencer loads the result into a buffer and sets a sticky flag, and that flag is what software sees.

Sequencer states and transitions:
- ST_IDLE goes to ST_CMP on the start pulse, and the operands are loaded on that edge.
- ST_CMP goes to ST_SUB_A when A > B, to ST_SUB_B when A < B, and to ST_DONE when A = B.
- ST_SUB_A replaces A with A − B, and ST_SUB_B replaces B with B − A. Both go back to ST_CMP.
- ST_DONE raises the completion pulse for one cycle and goes to ST_IDLE.

An operand of zero paired with a nonzero operand never reaches ST_DONE. Software must avoid that pairing.

Top module: `gcd_apb_regs`

## Requirements
- R1: The word at offset 0 (operand A) and the word at offset 4 (operand B) are readable and writable, and read back the last value written. The register index is decoded from paddr[4:2], and paddr[1:0] is ignored.
- R2: A write to offset 16 with bit 0 = 1 starts one computation. A write to offset 16 with bit 0 = 0 starts nothing, and the completion flag stays 0.
- R3: After completion, offset 8 reads gcd(A, B). That read clears the result buffer and the completion flag, so a second read of offset 8 returns 0.
- R4: Bit 0 of offset 12 reads 1 from completion until offset 8 is read, and 0 otherwise. Reading offset 12 does not clear it.
- R5: A start issued while a computation is running is ignored. Operand writes made during a computation do not change the pending result.
- R6: Bit 0 of offset 20 is a readable and writable interrupt enable. The irq output equals the completion flag ANDed with this enable.
- R7: Reads of offsets 16, 24 and 28 return 0. Writes to offsets 8 and 12 change neither the result nor the flag.
- R8: Every transfer completes with no wait state (pready = 1). A setup phase without penable has no side effect.
- R9: After reset, every readable register reads 0 and irq is 0.
- R10: Equal operands complete with that value as the result, including gcd(0, 0) = 0 with the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 5 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB transfer ready, always 1 |
| irq | output | 1 | Completion interrupt |

## Verification
The main function is exercised by a table of operand pairs, and each pair separates a different path:
- Ordinary pairs with a nontrivial divisor exercise both subtraction directions.
- Coprime pairs must end at 1.
- A pair where one operand divides the other ends after a single run of subtractions.
- Equal pairs, including 0 and 0, must go straight to completion.
- Near-full-width values expose any truncation in the subtractor or the comparators.

Directed cases then separate a destructive read from a non-destructive one. They also show a start issued while busy to be ignored, and a setup phase to have no effect.

// File: rtl/gcd_apb_pkg.sv
package gcd_apb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMP,
        ST_SUB_A,
        ST_SUB_B,
        ST_DONE
    } seq_state_e;

    localparam logic [2:0] IDX_OP_A   = 3'd0;
    localparam logic [2:0] IDX_OP_B   = 3'd1;
    localparam logic [2:0] IDX_RESULT = 3'd2;
    localparam logic [2:0] IDX_FLAG   = 3'd3;
    localparam logic [2:0] IDX_GO     = 3'd4;
    localparam logic [2:0] IDX_IEN    = 3'd5;

endpackage

// File: rtl/gcd_datapath.sv
module gcd_datapath #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         init,
    input  logic         load_a,
    input  logic         load_b,
    input  logic         swap,
    output logic         a_gt_b,
    output logic         a_lt_b,
    output logic [W-1:0] result
);
    logic [W-1:0] a_q, b_q;
    logic [W-1:0] minuend, subtrahend, diff;

    assign minuend    = swap ? b_q : a_q;
    assign subtrahend = swap ? a_q : b_q;
    assign diff       = minuend - subtrahend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (init) begin
            a_q <= op_a;
            b_q <= op_b;
        end else begin
            if (load_a) a_q <= diff;
            if (load_b) b_q <= diff;
        end
    end

    assign a_gt_b = a_q > b_q;
    assign a_lt_b = a_q < b_q;
    assign result = a_q;

    // R2: only one datapath action per cycle
    assert_ctrl_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({init, load_a, load_b}));
    // R3: a subtraction never wraps below zero
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_a |-> a_gt_b) and (load_b |-> a_lt_b));

endmodule

// File: rtl/gcd_sequencer.sv
module gcd_sequencer
    import gcd_apb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic a_gt_b,
    input  logic a_lt_b,
    output logic init,
    output logic load_a,
    output logic load_b,
    output logic swap,
    output logic done
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CMP;
            ST_CMP: begin
                if (a_gt_b)      state_d = ST_SUB_A;
                else if (a_lt_b) state_d = ST_SUB_B;
                else             state_d = ST_DONE;
            end
            ST_SUB_A: state_d = ST_CMP;
            ST_SUB_B: state_d = ST_CMP;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        init   = 1'b0;
        load_a = 1'b0;
        load_b = 1'b0;
        swap   = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE:  init = start;
            ST_CMP:   ;
            ST_SUB_A: load_a = 1'b1;
            ST_SUB_B: begin
                load_b = 1'b1;
                swap   = 1'b1;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    // R4: completion is a single-cycle pulse
    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5: a start seen while busy does not restart the sequence
    assert_busy_ignores_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUB_A && start) |=> state_q == ST_CMP);

endmodule

// File: rtl/gcd_regbank.sv
module gcd_regbank
    import gcd_apb_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [W-1:0]      pwdata,
    output logic [W-1:0]      prdata,
    output logic [W-1:0]      op_a,
    output logic [W-1:0]      op_b,
    output logic              go,
    input  logic              eng_done,
    input  logic [W-1:0]      eng_result,
    output logic              irq
);
    logic [2:0]   idx;
    logic         wr_acc, rd_acc;
    logic [W-1:0] a_q, b_q, res_q;
    logic         go_q, flag_q, ien_q;

    assign idx    = paddr[4:2];
    assign wr_acc = psel && penable && pwrite;
    assign rd_acc = psel && penable && !pwrite;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            go_q   <= 1'b0;
            ien_q  <= 1'b0;
            res_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            go_q <= wr_acc && (idx == IDX_GO) && pwdata[0];
            if (wr_acc && idx == IDX_OP_A) a_q   <= pwdata;
            if (wr_acc && idx == IDX_OP_B) b_q   <= pwdata;
            if (wr_acc && idx == IDX_IEN)  ien_q <= pwdata[0];
            if (eng_done) begin
                res_q  <= eng_result;
                flag_q <= 1'b1;
            end else if (rd_acc && idx == IDX_RESULT) begin
                res_q  <= '0;
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        prdata = '0;
        unique case (idx)
            IDX_OP_A:   prdata = a_q;
            IDX_OP_B:   prdata = b_q;
            IDX_RESULT: prdata = res_q;
            IDX_FLAG:   prdata = {{(W-1){1'b0}}, flag_q};
            IDX_IEN:    prdata = {{(W-1){1'b0}}, ien_q};
            default:    prdata = '0;
        endcase
    end

    assign op_a = a_q;
    assign op_b = b_q;
    assign go   = go_q;
    assign irq  = flag_q && ien_q;

    // R2: the start pulse lasts exactly one cycle
    assert_go_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |=> !go_q);
    // R4: completion sets the sticky flag
    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> flag_q);
    // R3: a result read clears buffer and flag
    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && idx == IDX_RESULT && !eng_done) |=> (!flag_q && res_q == '0));
    // R6: no interrupt without a pending result
    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);

endmodule

// File: rtl/gcd_apb_regs.sv
module gcd_apb_regs #(
    parameter int unsigned W      = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [W-1:0]      pwdata,
    output logic [W-1:0]      prdata,
    output logic              pready,
    output logic              irq
);
    logic [W-1:0] op_a, op_b, eng_result;
    logic         go, eng_done;
    logic         init, load_a, load_b, swap, a_gt_b, a_lt_b;

    assign pready = 1'b1;

    gcd_regbank #(.W(W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .op_a(op_a), .op_b(op_b), .go(go), .eng_done(eng_done),
        .eng_result(eng_result), .irq(irq)
    );

    gcd_sequencer seq_i (
        .clk(clk), .rst_n(rst_n), .start(go), .a_gt_b(a_gt_b), .a_lt_b(a_lt_b),
        .init(init), .load_a(load_a), .load_b(load_b), .swap(swap), .done(eng_done)
    );

    gcd_datapath #(.W(W)) dp_i (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .init(init),
        .load_a(load_a), .load_b(load_b), .swap(swap),
        .a_gt_b(a_gt_b), .a_lt_b(a_lt_b), .result(eng_result)
    );

    // R8: a result read in setup phase alone has no effect on a pending flag
    assert_setup_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable && !eng_done && regs_i.flag_q) |=> regs_i.flag_q);

endmodule

// File: tb/gcd_apb_regs_tb.sv
module gcd_apb_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam logic [95:0] VEC [NVEC] = '{
        {32'd48,         32'd18,         32'd6},
        {32'd17,         32'd5,          32'd1},
        {32'd7,          32'd7,          32'd7},
        {32'd36,         32'd48,         32'd12},
        {32'd461952,     32'd116298,     32'd18},
        {32'd461952,     32'd1162,       32'd2},
        {32'd1024,       32'd4096,       32'd1024},
        {32'hFFFF_FFFE,  32'h7FFF_FFFF,  32'h7FFF_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, irq;
    int n_chk = 0;
    int n_fail = 0;
    logic pready_seen = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    gcd_apb_regs dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        if (!pready) pready_seen = 1'b0;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        d = prdata;
        if (!pready) pready_seen = 1'b0;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wait_flag(input string req);
        logic [31:0] f;
        f = '0;
        for (int i = 0; i < 20000 && f[0] !== 1'b1; i++) apb_rd(5'd12, f);
        chk(req, f, 32'd1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        // R9 reset state, sampled before reset is released
        chk("R9 irq", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            apb_rd(5'(k * 4), r);
            chk("R9 reset reg", r, 32'd0);
        end

        // R1 operand read-back, low address bits ignored
        apb_wr(5'd0, 32'hA5A5_0001);
        apb_wr(5'd7, 32'h0BAD_F00D);
        apb_rd(5'd0, r); chk("R1 op A", r, 32'hA5A5_0001);
        apb_rd(5'd4, r); chk("R1 op B", r, 32'h0BAD_F00D);

        // R8 setup phase alone writes nothing
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 5'd0; pwdata = 32'h1234_5678;
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
        apb_rd(5'd0, r); chk("R8 setup only", r, 32'hA5A5_0001);

        // R2 writing 0 to start does nothing
        apb_wr(5'd16, 32'h0000_0000);
        repeat (20) @(negedge clk);
        apb_rd(5'd12, r); chk("R2 no start", r, 32'd0);

        // R3 table of operand pairs
        for (int v = 0; v < NVEC; v++) begin
            apb_wr(5'd0, VEC[v][95:64]);
            apb_wr(5'd4, VEC[v][63:32]);
            apb_wr(5'd16, 32'd1);
            wait_flag("R4 flag after start");
            apb_rd(5'd8, r);  chk("R3 gcd result", r, VEC[v][31:0]);
            apb_rd(5'd12, r); chk("R3 flag cleared", r, 32'd0);
            apb_rd(5'd8, r);  chk("R3 result cleared", r, 32'd0);
        end

        // R10 gcd(0,0)
        apb_wr(5'd0, 32'd0);
        apb_wr(5'd4, 32'd0);
        apb_wr(5'd16, 32'd1);
        wait_flag("R10 zero pair completes");
        apb_rd(5'd8, r); chk("R10 zero result", r, 32'd0);

        // R5 restart and operand change while busy; R6 interrupt
        apb_wr(5'd20, 32'd1);
        apb_rd(5'd20, r); chk("R6 enable readback", r, 32'd1);
        apb_wr(5'd0, 32'd100000);
        apb_wr(5'd4, 32'd35);
        apb_wr(5'd16, 32'd1);
        apb_wr(5'd0, 32'd9);
        apb_wr(5'd4, 32'd6);
        apb_wr(5'd16, 32'd1);
        chk("R6 irq low while busy", {31'd0, irq}, 32'd0);
        wait_flag("R5 flag");
        @(negedge clk);
        chk("R6 irq high", {31'd0, irq}, 32'd1);
        apb_rd(5'd12, r); chk("R4 flag kept after flag read", r, 32'd1);
        // R7 writes to read-only offsets ignored
        apb_wr(5'd8, 32'hFFFF_FFFF);
        apb_wr(5'd12, 32'd0);
        apb_rd(5'd12, r); chk("R7 flag write ignored", r, 32'd1);
        apb_wr(5'd20, 32'd0);
        @(negedge clk);
        chk("R6 irq masked", {31'd0, irq}, 32'd0);
        apb_wr(5'd20, 32'd1);
        apb_rd(5'd8, r); chk("R5 busy start ignored", r, 32'd5);
        @(negedge clk);
        chk("R6 irq cleared by read", {31'd0, irq}, 32'd0);

        // R7 unmapped and write-only offsets read 0
        apb_rd(5'd16, r); chk("R7 start reads 0", r, 32'd0);
        apb_rd(5'd24, r); chk("R7 offset 24", r, 32'd0);
        apb_rd(5'd28, r); chk("R7 offset 28", r, 32'd0);

        chk("R8 pready", {31'd0, pready_seen}, 32'd1);
        summary();
        $finish;
    end

endmodule